// File: doc/BRIEF.md
# Rewindable FIFO with Occupancy Flags

A single-clock first-in/first-out buffer of 9-bit words whose depth is set by a parameter (1024 by default). Writes and reads are requested with active-low strobes sampled on the rising clock edge. Words leave in the order they arrived. Four active-low flags show how full the buffer is: empty, full, more-than-half, and one shared "band" flag. The band flag is high only while occupancy sits in the middle range, and low near both ends.

A rewind input moves the read pointer back to storage location zero and leaves the write pointer alone. Everything written since the last reset can then be read out again. Storage is used once per reset: the write pointer never wraps, so after the last location has been filled, further writes are refused until the next reset. Read data is registered. It appears on the clock after an accepted read, qualified by a valid bit that an active-low output enable can suppress without stopping the read pointer.

Top module: `rewind_fifo`

## Requirements
- R1: After reset is asserted low, `empty_n`=0, `full_n`=1, `half_n`=1, `band_n`=0 and `dout_vld`=0.
- R2: Accepted reads return words in the order they were written. Each word is on `dout`, with `dout_vld`=1, in the cycle right after the clock edge that accepted the read.
- R3: A write while `full_n`=0 is ignored. The dropped word is never read out, and the stored words are unchanged.
- R4: A read while `empty_n`=0 is ignored. It produces no valid output and does not move the read pointer.
- R5: `half_n` is 0 exactly when occupancy is greater than DEPTH/2.
- R6: `band_n` is 1 exactly when occupancy is between DEPTH/8 and DEPTH-DEPTH/8, both inclusive. It is 0 at every other occupancy, including empty and full.
- R7: `empty_n` is 0 exactly at occupancy 0, and `full_n` is 0 exactly at occupancy DEPTH.
- R8: A clock edge with `rt_n`=0 sets the read pointer to location zero and keeps the write pointer. Occupancy becomes the number of words written since reset, the flags follow it, and later reads replay from the first word written.
- R9: A read accepted while `oe_n`=1 advances the read pointer but leaves `dout_vld`=0.
- R10: A read and a write in the same cycle, neither blocked, are both performed, and occupancy is unchanged. On an empty buffer only the write takes effect.
- R11: Read or write strobes that are asserted while reset or rewind is active are dropped.
- R12: Once DEPTH words have been written since reset, further writes are ignored until the next reset, even while `full_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write request, active low |
| rd_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Rewind read pointer to location zero, active low |
| oe_n | input | 1 | Output enable for the valid qualifier, active low |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data |
| dout_vld | output | 1 | Read data valid |
| empty_n | output | 1 | Low when the buffer holds no words |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when occupancy exceeds DEPTH/2 |
| band_n | output | 1 | High only while occupancy is within the middle band |

## Verification
Every result is due one clock edge after the stimulus that causes it. The flags follow the pointer registers, so they change at the edge that accepts a write, read or rewind. Read data and its valid bit are registered at that same edge. The bench drives stimulus on the falling edge, lets one rising edge pass, and samples on the following falling edge. At that point the scoreboard pops exactly the words the model scheduled for that edge, and the flags are compared against the model's occupancy.

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_vld,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             band_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LIMIT     = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LOW_MARK  = CW'(DEPTH / 8);
  localparam logic [CW-1:0] HIGH_MARK = CW'(DEPTH - DEPTH / 8);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    wptr, rptr, count;
  logic             wr_ok, rd_ok;

  assign count   = wptr - rptr;
  assign empty_n = (count != '0);
  assign full_n  = (count != LIMIT);
  assign half_n  = !(count > HALF_MARK);
  assign band_n  = (count >= LOW_MARK) && (count <= HIGH_MARK);

  assign wr_ok = !wr_n && rt_n && full_n && (wptr != LIMIT);
  assign rd_ok = !rd_n && rt_n && empty_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= rd_ok && !oe_n;
      if (!rt_n)
        rptr <= '0;
      else if (rd_ok)
        rptr <= rptr + CW'(1);
      if (wr_ok)
        wptr <= wptr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok)
      mem[wptr[AW-1:0]] <= din;
    if (rd_ok)
      dout <= mem[rptr[AW-1:0]];
  end
endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int DEPTH = 1024,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic          oe_n,
  input logic          dout_vld,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          band_n,
  input logic [CW-1:0] wptr,
  input logic [CW-1:0] rptr,
  input logic [CW-1:0] count
);
  assert_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_n && rd_n && rt_n) |=> !full_n);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_n && rt_n) |=> (!dout_vld && $stable(rptr)));

  assert_half_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> empty_n);

  assert_band_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n || !full_n) |-> !band_n);

  assert_flag_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n || full_n));

  assert_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rptr == '0 && $stable(wptr)));

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dout_vld);

  assert_same_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !rd_n && rt_n && empty_n && full_n && wptr != CW'(DEPTH)) |=> $stable(count));

  assert_rewind_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> !dout_vld);

  assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr == CW'(DEPTH)) |=> (wptr == CW'(DEPTH)));
endmodule

bind rewind_fifo rewind_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .oe_n(oe_n),
  .dout_vld(dout_vld), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
  .band_n(band_n), .wptr(wptr), .rptr(rptr), .count(count)
);

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
  localparam int W = 9;
  localparam int D = 64;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0, wr_n = 1, rd_n = 1, rt_n = 1, oe_n = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_vld, empty_n, full_n, half_n, band_n;

  rewind_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_vld(dout_vld), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n), .band_n(band_n)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic [W-1:0] stored [D];
  int mw = 0, mr = 0, mcount = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_flags();
    chk("R7 empty_n", empty_n, int'(mcount != 0));
    chk("R7 full_n", full_n, int'(mcount != D));
    chk("R5 half_n", half_n, int'(!(mcount > D / 2)));
    chk("R6 band_n", band_n, int'(mcount >= D / 8 && mcount <= D - D / 8));
  endtask

  task automatic wrap_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Driver: starts at a falling edge, ends at the next falling edge.
  task automatic cyc(bit w, bit r, bit rt, bit oe, logic [W-1:0] d, string tag);
    bit wacc, racc;
    wr_n = !w; rd_n = !r; rt_n = !rt; oe_n = !oe; din = d;
    @(posedge clk);
    if (rt) begin
      mr = 0;
      mcount = mw;
    end else begin
      wacc = w && mcount < D && mw < D;
      racc = r && mcount > 0;
      if (racc) begin
        if (oe) begin
          exp_q.push_back(stored[mr]);
          tag_q.push_back(tag);
        end
        mr++;
      end
      if (wacc) begin
        stored[mw] = d;
        mw++;
      end
      mcount += int'(wacc) - int'(racc);
    end
    @(negedge clk);
    wr_n = 1; rd_n = 1; rt_n = 1;
    check_flags();
  endtask

  task automatic do_reset();
    rst_n = 0; wr_n = 0; rd_n = 0; din = '1;  // R11: strobes held during reset
    repeat (2) @(negedge clk);
    wr_n = 1; rd_n = 1; rst_n = 1;
    mw = 0; mr = 0; mcount = 0;
    exp_q.delete(); tag_q.delete();
    chk("R1 dout_vld", dout_vld, 0);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 half_n", half_n, 1);
    chk("R1 band_n", band_n, 0);
  endtask

  // Monitor: pops words due at this sample point.
  always @(negedge clk) begin
    logic [W-1:0] e;
    string t;
    if (rst_n) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " dout_vld"}, dout_vld, 1);
        chk({t, " dout"}, dout, e);
      end else if (dout_vld) begin
        checks++;
        fails++;
        $display("FAIL R4/R9 unexpected valid: actual %0d expected 0", dout);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    @(negedge clk);
    do_reset();

    cyc(0, 1, 0, 1, '0, "R4");
    chk("R4 empty read no data", dout_vld, 0);

    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 1, W'(16 + i), "R2");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, '0, "R2");
    cyc(1, 1, 0, 1, W'(9'h1AA), "R10");
    cyc(0, 1, 0, 0, '0, "R9");
    chk("R9 valid suppressed", dout_vld, 0);
    cyc(0, 1, 0, 1, '0, "R9");
    while (mcount > 0) cyc(0, 1, 0, 1, '0, "R2");
    cyc(1, 1, 0, 1, W'(9'h0F0), "R10");
    chk("R10 write kept on empty", empty_n, 1);
    cyc(0, 1, 0, 1, '0, "R10");

    do_reset();
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 1, W'(100 + i), "R5");
    for (int i = 0; i < 15; i++) cyc(0, 1, 0, 1, '0, "R2");
    cyc(1, 1, 1, 1, W'(9'h155), "R11");
    chk("R11 no valid during rewind", dout_vld, 0);
    chk("R8 band after rewind", band_n, 1);
    while (mcount > 0) cyc(0, 1, 0, 1, '0, "R8");

    do_reset();
    for (int i = 0; i < D + 1; i++) cyc(1, 0, 0, 1, W'(200 + i), "R3");
    chk("R3 full_n low", full_n, 0);
    for (int i = 0; i < D; i++) cyc(0, 1, 0, 1, '0, "R3");
    chk("R3 drained", empty_n, 0);
    cyc(1, 0, 0, 1, W'(9'h077), "R12");
    chk("R12 write past end ignored", empty_n, 0);
    cyc(0, 0, 1, 1, '0, "R8");
    chk("R8 full after rewind", full_n, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, '0, "R8");
    cyc(1, 0, 0, 1, W'(9'h033), "R12");
    chk("R12 still refused", full_n, 1);

    repeat (2) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    wrap_up();
  end
endmodule